// File: doc/BRIEF.md
# Randomized Backpressure Congestor

This block sits on the flow-control path between a producer and a consumer and, at pseudo-random moments, pushes that path into its blocking state. In ready mode it pulls the producer-facing ready low even though the consumer could take the beat. In full mode it ORs a congest term into the consumer's full indication, so full reads high even when there is room. The aim is to shake the timing of the surrounding logic during simulation without changing what is transferred. The same wrapper serves busy, full and ready style signals.

The random source is a 16-bit maximal-length LFSR that a seed input can load. The LFSR advances once per cycle. In any cycle where its value is a multiple of the programmed period, a one-cycle congestion slot opens. Congestion closes the path on both sides in the same cycle. The producer sees no ready and the consumer sees no valid, so a beat can never be accepted on one side and lost or repeated on the other. Congestion is withheld while the consumer has an offered beat still pending, so the consumer-side valid is never withdrawn. With the enable low the block is a purely combinational pass-through. A saturating counter records how many cycles were congested, for coverage.

Top module: `bp_congestor`

## Requirements
- R1: After reset the LFSR holds 16'h0001, the congestion count is 0 and no beat is pending.
- R2: A high `seed_load` loads `seed_val` into the LFSR at the next edge (a zero seed loads 16'h0001). Otherwise the LFSR steps every cycle: the state shifts left by one and the new bit 0 is the XOR of old bits 15, 13, 12 and 10.
- R3: `cong_active` is high in a cycle exactly when `cfg_en` is high, `period_val` is nonzero, the current LFSR value modulo `period_val` is zero, and no downstream beat is pending.
- R4: With `full_mode`=1, `dn_flow` is a full indication (1 = cannot accept), and `up_ready` = NOT(`dn_flow` OR `cong_active`).
- R5: With `full_mode`=0, `dn_flow` is a ready indication (1 = can accept), and `up_ready` = `dn_flow` AND NOT `cong_active`.
- R6: `dn_valid` = `up_valid` AND NOT `cong_active`, and `dn_data` always equals `up_data`. An upstream transfer happens in exactly the cycles of a downstream transfer, so beats arrive complete and in order.
- R7: A beat is pending in a cycle when, in the previous cycle, `dn_valid` was high and the consumer could not accept it. Congestion never starts while a beat is pending, so an offered downstream valid stays up until it is accepted.
- R8: With `cfg_en` low, `up_ready` follows the consumer's acceptance, `dn_valid` follows `up_valid`, and the count does not change.
- R9: `cong_count` rises by one at each edge that ends a congested cycle and saturates at its all-ones value.
- R10: A period of 0 never congests. A period of 1 congests every cycle in which no beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enables congestion injection |
| seed_load | input | 1 | Loads `seed_val` into the LFSR |
| seed_val | input | 16 | LFSR seed |
| period_val | input | PERIOD_W | Congestion period (0 disables) |
| full_mode | input | 1 | 1: `dn_flow` is full; 0: `dn_flow` is ready |
| up_valid | input | 1 | Producer valid |
| up_ready | output | 1 | Gated ready toward the producer |
| up_data | input | DATA_W | Producer data |
| dn_valid | output | 1 | Gated valid toward the consumer |
| dn_flow | input | 1 | Consumer flow indication (ready or full) |
| dn_data | output | DATA_W | Data toward the consumer |
| cong_active | output | 1 | Congestion forced this cycle |
| cong_count | output | CNT_W | Saturating count of congested cycles |

## Verification
The gating is driven with a consumer that is always willing, one that refuses for long stretches, and one that toggles pseudo-randomly, in both flow polarities. The willing consumer isolates the LFSR and period decision. The refusing consumer shows the suppression that protects a pending beat. The toggling consumer, together with a held-until-accepted producer stream, shows that sent and received sequences match. Periods 0 and 1 and a seeded period-2 run separate the disable case, the always-hit case and the LFSR stepping. A narrow counter shows saturation.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_RST = 16'h0001;

  // Fibonacci step, taps at 16/14/13/11 (maximal length)
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur);
    return {cur[LFSR_W-2:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? LFSR_RST : s;
  endfunction

  function automatic logic slot_hit(input logic [LFSR_W-1:0] cur,
                                    input logic [LFSR_W-1:0] per);
    if (per == '0) return 1'b0;
    return (cur % per) == '0;
  endfunction
endpackage

// File: rtl/bpc_lfsr.sv
module bpc_lfsr
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] nxt;

  always_comb begin
    nxt = load ? seed_fix(seed) : lfsr_step(state);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_RST;
    else        state <= nxt;
  end

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  p_lfsr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> state == $past(seed));
endmodule

// File: rtl/bpc_gate.sv
module bpc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic full_mode,
  input  logic up_valid,
  input  logic dn_flow,
  output logic up_ready,
  output logic dn_valid,
  output logic cong,
  output logic rdy_eff
);
  logic pend_q;
  logic offer_stuck;

  assign rdy_eff     = full_mode ? ~dn_flow : dn_flow;
  assign cong        = en & hit & ~pend_q;
  assign dn_valid    = up_valid & ~cong;
  assign up_ready    = rdy_eff & ~cong;
  assign offer_stuck = dn_valid & ~rdy_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= offer_stuck;
  end

  // R7: a refused offer is never followed by congestion
  p_no_cong_after_stuck_r7: assert property (@(posedge clk) disable iff (!rst_n)
    offer_stuck |=> !cong);
  // R6: both sides transfer together
  p_xfer_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) == (dn_valid && rdy_eff));
endmodule

// File: rtl/bpc_counter.sv
module bpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc || cnt == CNT_MAX) |=> $stable(cnt));
endmodule

// File: rtl/bp_congestor.sv
module bp_congestor
  import bpc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 8,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                seed_load,
  input  logic [LFSR_W-1:0]   seed_val,
  input  logic [PERIOD_W-1:0] period_val,
  input  logic                full_mode,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [DATA_W-1:0]   up_data,
  output logic                dn_valid,
  input  logic                dn_flow,
  output logic [DATA_W-1:0]   dn_data,
  output logic                cong_active,
  output logic [CNT_W-1:0]    cong_count
);
  localparam int PAD_W = LFSR_W - PERIOD_W;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] per_ext;
  logic              slot;
  logic              rdy_eff;

  assign per_ext = {{PAD_W{1'b0}}, period_val};
  assign slot    = slot_hit(lfsr_q, per_ext);
  assign dn_data = up_data;

  bpc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_val), .state(lfsr_q)
  );

  bpc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .hit(slot), .full_mode(full_mode),
    .up_valid(up_valid), .dn_flow(dn_flow), .up_ready(up_ready),
    .dn_valid(dn_valid), .cong(cong_active), .rdy_eff(rdy_eff)
  );

  bpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cong_active), .cnt(cong_count)
  );

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (dn_valid == up_valid) && (up_ready == rdy_eff));
  p_period_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (period_val == '0) |-> !cong_active);
  p_cong_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cong_active |-> !dn_valid && !up_ready);
endmodule

// File: tb/tb_bp_congestor.sv
module tb_bp_congestor;
  localparam int TB_CNT_W = 6;
  localparam int CMAX = (1 << TB_CNT_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_en, seed_load, full_mode, up_valid, dn_flow;
  logic [15:0] seed_val;
  logic [7:0]  period_val, up_data;
  logic        up_ready, dn_valid, cong_active;
  logic [7:0]  dn_data;
  logic [TB_CNT_W-1:0] cong_count;

  bp_congestor #(.DATA_W(8), .PERIOD_W(8), .CNT_W(TB_CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .seed_load(seed_load),
    .seed_val(seed_val), .period_val(period_val), .full_mode(full_mode),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_flow(dn_flow), .dn_data(dn_data),
    .cong_active(cong_active), .cong_count(cong_count)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  // bench model state
  logic [15:0] m_lfsr;
  logic        m_pend;
  int          m_cnt;
  logic [31:0] rng = 32'h1234_5678;
  logic [7:0]  sent [0:255];
  logic [7:0]  rcvd [0:255];
  int          n_sent, n_rcvd;

  function automatic logic [15:0] mdl_next(input logic [15:0] l);
    logic fb;
    fb = ^(l & 16'hB400);
    return (l << 1) | {15'd0, fb};
  endfunction

  function automatic logic [31:0] rnd_next(input logic [31:0] r);
    return r * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge phase, check combinational outputs, step model
  task automatic cyc(input logic v, input logic fl, input logic [7:0] d, input string tag);
    logic rdy, hit, cg, ev, er;
    up_valid = v; dn_flow = fl; up_data = d;
    #2;
    rdy = full_mode ? ~fl : fl;
    hit = (period_val != 0) && ((m_lfsr % {8'd0, period_val}) == 0);
    cg  = cfg_en && hit && !m_pend;
    ev  = v && !cg;
    er  = rdy && !cg;
    chk({tag, " cong"}, int'(cong_active), int'(cg));
    chk({tag, " dn_valid"}, int'(dn_valid), int'(ev));
    chk({tag, " up_ready"}, int'(up_ready), int'(er));
    chk({tag, " data R6"}, int'(dn_data), int'(d));
    chk({tag, " count"}, int'(cong_count), m_cnt);
    if (up_valid && up_ready && n_sent < 256) begin sent[n_sent] = d; n_sent++; end
    if (dn_valid && rdy && n_rcvd < 256) begin rcvd[n_rcvd] = dn_data; n_rcvd++; end
    @(posedge clk);
    m_lfsr = seed_load ? ((seed_val == 0) ? 16'h0001 : seed_val) : mdl_next(m_lfsr);
    m_pend = ev && !rdy;
    if (cg && m_cnt < CMAX) m_cnt++;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_en = 0; seed_load = 0; seed_val = 0; period_val = 1;
    full_mode = 0; up_valid = 0; dn_flow = 1; up_data = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_lfsr = 16'h0001; m_pend = 0; m_cnt = 0;
    chk("R1 count after reset", int'(cong_count), 0);
    cyc(1, 1, 8'h11, "R1");
    cfg_en = 1; period_val = 1;
    cyc(0, 1, 8'h12, "R1 lfsr=1 with period 1");
  endtask

  task automatic t_passthru;
    cfg_en = 0; period_val = 1;
    for (int i = 0; i < 20; i++) begin
      rng = rnd_next(rng);
      full_mode = rng[20];
      cyc(rng[17], rng[18], rng[31:24], "R8 bypass");
    end
    full_mode = 0;
  endtask

  task automatic t_seed;
    cfg_en = 1; period_val = 2; seed_load = 1; seed_val = 16'hACE1;
    cyc(0, 1, 8'h00, "R2 load");
    seed_load = 0;
    for (int i = 0; i < 24; i++) cyc(0, 1, 8'h00, "R2 R3 step period2");
    seed_load = 1; seed_val = 16'h0000;
    cyc(0, 1, 8'h00, "R2 zero seed");
    seed_load = 0;
    period_val = 1;
    cyc(0, 1, 8'h00, "R2 after zero seed");
  endtask

  task automatic t_modes;
    cfg_en = 1; period_val = 3;
    full_mode = 0;
    for (int i = 0; i < 20; i++) cyc(1, 1, 8'(i), "R5 ready mode");
    full_mode = 1;
    for (int i = 0; i < 20; i++) cyc(1, 0, 8'(i), "R4 full mode");
    for (int i = 0; i < 4; i++)  cyc(1, 1, 8'(i), "R4 full asserted");
    full_mode = 0;
  endtask

  task automatic t_periods;
    cfg_en = 1; period_val = 0;
    for (int i = 0; i < 12; i++) cyc(1, 1, 8'hA0, "R10 period0");
    period_val = 1;
    for (int i = 0; i < 8; i++) cyc(0, 1, 8'hA1, "R10 period1");
  endtask

  task automatic t_stall;
    cfg_en = 1; period_val = 3; full_mode = 0;
    for (int i = 0; i < 20; i++) cyc(1, 0, 8'h5A, "R7 refused");
    chk("R7 valid held while refused", int'(dn_valid), 1);
    for (int i = 0; i < 6; i++) cyc(1, 1, 8'h5B, "R7 release");
  endtask

  task automatic t_order;
    logic [7:0] d;
    logic v;
    cfg_en = 1; period_val = 2; full_mode = 0; n_sent = 0; n_rcvd = 0;
    d = 8'h40; v = 1'b0;
    for (int i = 0; i < 120; i++) begin
      logic fl, acc;
      rng = rnd_next(rng);
      fl = rng[21] | rng[22];
      if (!v) v = rng[19];
      up_valid = v; dn_flow = fl; #1;
      acc = up_ready;
      cyc(v, fl, d, "R6 stream");
      if (v && acc) begin d = d + 8'd1; v = 1'b0; end
    end
    chk("R6 sent==received count", n_rcvd, n_sent);
    for (int i = 0; i < n_sent && i < n_rcvd; i++)
      chk("R6 order", int'(rcvd[i]), int'(sent[i]));
    chk("R6 some beats moved", int'(n_sent > 10), 1);
  endtask

  task automatic t_sat;
    cfg_en = 1; period_val = 1;
    for (int i = 0; i < CMAX + 8; i++) cyc(0, 1, 8'h00, "R9 saturate");
    chk("R9 saturated value", int'(cong_count), CMAX);
    cfg_en = 0;
    cyc(0, 1, 8'h00, "R8 R9 disabled hold");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<100000", n_cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_passthru();
    t_seed();
    t_modes();
    t_periods();
    t_stall();
    t_order();
    t_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule